// File: doc/BRIEF.md
# Two-Master Bus Hold Arbiter

This block decides which of two masters owns a shared local bus. One unit comes out of reset as the primary master. It owns the bus by default and gives the bus up when the other master raises a hold request. The other unit comes out of reset as the secondary master. It starts without the bus, asks for it when it has work, and gives it back when that work is done. Both roles use the same two arbitration pins. In the primary role the input is a hold request and the output is a hold acknowledge. In the secondary role the output is a hold request and the input is the grant coming back.

The block follows the bus through idle (Ti), address (Ta), data, a one-cycle release step and hold (Th). It drives one enable that covers the three-state and open-drain bus drivers. It pulses a start strobe when a transaction may begin. A raw system-reset input is qualified against a minimum length. At the end of a qualified reset, a strap pin sampled during reset fixes the role. While reset is active the block stays quiet.

Top module: `bus_hold_arbiter`

## Requirements
- R1: While the block is held in reset, drv_oe_o, arb_out_o and xfer_start_o are 0 and bus_state_o is 0. The block is held in reset after rst_n, during a synchronized sys_rst_i, and after a rejected reset. Toggling arb_in_i, xfer_req_i or xfer_done_i has no effect while it is held.
- R2: A sys_rst_i pulse high for at least MIN_RST_CYCLES (41) clock cycles is accepted: rst_short_o goes to 0 and operation starts. A shorter pulse sets rst_short_o to 1 and leaves the block held in reset until an accepted reset arrives.
- R3: The value of init_sel_i during an accepted reset fixes the role, with 1 meaning primary and 0 meaning secondary, and role_primary_o shows it. A primary master starts in idle (bus_state_o=1) with drv_oe_o=1. A secondary master starts in hold (bus_state_o=5) with drv_oe_o=0. Changing init_sel_i later has no effect.
- R4: In the primary role, when the synchronized hold request is seen in idle, it wins over a pending xfer_req_i. The block enters release (4) and then hold (5), and it asserts arb_out_o only in hold.
- R5: A hold request that arrives during a transfer (state 3) is not honoured until xfer_done_i. Until then the state stays 3, drv_oe_o stays 1 and arb_out_o stays 0.
- R6: In the primary role, when the hold request drops in hold, arb_out_o returns to 0. The next state is address (2) if xfer_req_i is 1, and idle (1) otherwise.
- R7: In the secondary role, xfer_req_i in hold raises arb_out_o. arb_out_o stays high while no grant arrives, and it stays high for as long as the bus is owned. A synchronized grant then gives address (2). When xfer_done_i arrives with no further request, the block releases (4) and then returns to hold (5) with arb_out_o at 0.
- R8: In the primary role, drv_oe_o is 0 in the cycle before arb_out_o rises. drv_oe_o and arb_out_o are never 1 together.
- R9: xfer_start_o is a single-cycle pulse. It is given only in address state (2), where drv_oe_o is 1. Every address cycle is followed by a data cycle (3).
- R10: The bus_state_o codes are 0 reset, 1 idle, 2 address, 3 data, 4 release and 5 hold. In the primary role the only moves are 1→{1,2,4}, 2→3, 3→{1,2,3,4}, 4→5 and 5→{1,2,5}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| sys_rst_i | input | 1 | Raw system reset request, active high, qualified by length |
| init_sel_i | input | 1 | Role strap sampled during reset (1 primary, 0 secondary) |
| arb_in_i | input | 1 | Hold request (primary) or grant received (secondary), asynchronous |
| xfer_req_i | input | 1 | A transaction is pending; held until xfer_start_o |
| xfer_done_i | input | 1 | Current transaction has finished |
| arb_out_o | output | 1 | Hold acknowledge (primary) or hold request (secondary) |
| drv_oe_o | output | 1 | Enable for three-state and open-drain bus drivers |
| xfer_start_o | output | 1 | Transaction may start this cycle |
| bus_state_o | output | 3 | Bus state code |
| role_primary_o | output | 1 | Latched role, 1 = primary |
| rst_short_o | output | 1 | Last reset pulse was too short |

## Verification
A wrong state in this block appears on the arbitration pin and the driver enable within one cycle, because both are decoded straight from the state register. The dangerous case is both masters driving the bus at once, and it shows as drv_oe_o and arb_out_o high together or as the acknowledge rising without the release cycle before it. Any error in the synchronizer or reset counter moves the first state change by whole cycles. The bench therefore samples at the exact cycle it predicts and checks both sides of the 41-cycle boundary.

// File: rtl/hold_arb_pkg.sv
// Shared types for the two-master bus hold arbiter.
// Assumes: state codes are visible at the top ports and must stay stable.
package hold_arb_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [2:0] {
        ST_RESET = 3'd0,
        ST_IDLE  = 3'd1,
        ST_ADDR  = 3'd2,
        ST_DATA  = 3'd3,
        ST_REL   = 3'd4,
        ST_HOLD  = 3'd5
    } bus_st_e;

    localparam int DEF_SYNC_STAGES = 2;
    localparam int DEF_MIN_RST     = 41;
endpackage

// File: rtl/hold_sync.sv
// Multi-stage flop synchronizer for a vector of independent single-bit
// asynchronous inputs.
// Assumes: each bit is slow enough to be sampled individually (no bus coherency).
module hold_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // Shift the raw inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rst_qualify.sv
// Reset qualifier: measures how long the synchronized system reset is held.
// It releases the block only after a pulse of at least MIN_CYCLES, and it
// latches the role strap while reset is active.
// Assumes: rst_req_i is already synchronized; init_pin_i is a static strap.
module rst_qualify #(
    parameter int MIN_CYCLES = 41
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_req_i,
    input  logic init_pin_i,
    output logic run_o,
    output logic primary_o,
    output logic short_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CW = $clog2(MIN_CYCLES + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(MIN_CYCLES);

    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic          role_q;
    logic          short_q;

    // Count reset length, sample strap, and decide at the falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            run_q   <= 1'b0;
            role_q  <= 1'b0;
            short_q <= 1'b0;
        end else if (rst_req_i) begin
            run_q  <= 1'b0;
            role_q <= init_pin_i;
            if (cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (cnt_q != '0) begin
            cnt_q <= '0;
            if (cnt_q == CNT_MAX) begin
                run_q   <= 1'b1;
                short_q <= 1'b0;
            end else begin
                short_q <= 1'b1;
            end
        end
    end

    assign run_o     = run_q;
    assign primary_o = role_q;
    assign short_o   = short_q;

    // R2: operation starts only after a counted pulse reached the minimum.
    assert_qualified_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_q) |-> ($past(cnt_q) == CNT_MAX))
        else $error("released after a short reset");

    // R3: the role cannot change while the block is running.
    assert_role_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(run_q)) |-> $stable(role_q))
        else $error("role changed during operation");

    // R2: a short pulse never lets the block run.
    assert_short_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(short_q) |-> !run_q)
        else $error("running after a rejected reset");
endmodule

// File: rtl/hold_fsm.sv
// Bus ownership state machine for both arbitration roles.
// Primary: owns the bus and yields it to a hold request at a transfer boundary.
// Secondary: requests the bus, waits for the grant and returns it when idle.
// Driver enable drops one full cycle (release state) before the bus is handed over.
// Assumes: hold_i is synchronized; xfer_req_i is held until xfer_start_o.
module hold_fsm
    import hold_arb_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    run_i,
    input  logic    primary_i,
    input  logic    hold_i,
    input  logic    xfer_req_i,
    input  logic    xfer_done_i,
    output bus_st_e state_o,
    output logic    arb_out_o,
    output logic    drv_oe_o,
    output logic    xfer_start_o
);
    timeunit 1ns;
    timeprecision 1ps;

    bus_st_e state_q;
    bus_st_e state_d;
    logic    req_q;

    // Next-state selection for both roles.
    always_comb begin
        state_d = state_q;
        if (!run_i) begin
            state_d = ST_RESET;
        end else begin
            unique case (state_q)
                ST_RESET: state_d = primary_i ? ST_IDLE : ST_HOLD;
                ST_IDLE: begin
                    if (!primary_i || hold_i) state_d = ST_REL;
                    else if (xfer_req_i)      state_d = ST_ADDR;
                end
                ST_ADDR: state_d = ST_DATA;
                ST_DATA: begin
                    if (xfer_done_i) begin
                        if (primary_i && hold_i) state_d = ST_REL;
                        else if (xfer_req_i)     state_d = ST_ADDR;
                        else if (primary_i)      state_d = ST_IDLE;
                        else                     state_d = ST_REL;
                    end
                end
                ST_REL: state_d = ST_HOLD;
                ST_HOLD: begin
                    if (primary_i) begin
                        if (!hold_i) state_d = xfer_req_i ? ST_ADDR : ST_IDLE;
                    end else if (req_q && hold_i) begin
                        state_d = ST_ADDR;
                    end
                end
                default: state_d = ST_RESET;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RESET;
        else        state_q <= state_d;
    end

    // Secondary-role request: raise on pending work, drop once released.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            req_q <= 1'b0;
        end else if (state_q == ST_REL) begin
            req_q <= 1'b0;
        end else if (!primary_i && state_q == ST_HOLD && xfer_req_i && !hold_i) begin
            req_q <= 1'b1;
        end
    end

    assign state_o      = state_q;
    assign drv_oe_o     = (state_q == ST_IDLE) || (state_q == ST_ADDR) || (state_q == ST_DATA);
    assign xfer_start_o = (state_q == ST_ADDR);
    assign arb_out_o    = primary_i ? (state_q == ST_HOLD) : req_q;

    // R8: acknowledge rises only after a cycle with drivers off.
    assert_oe_off_before_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (primary_i && $rose(arb_out_o)) |-> !$past(drv_oe_o))
        else $error("acknowledge without prior driver release");

    // R8: never drive and acknowledge together.
    assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(primary_i && arb_out_o && drv_oe_o))
        else $error("driver enable overlaps acknowledge");

    // R5: a transfer in progress is not cut short.
    assert_transfer_completes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && state_q == ST_DATA && !xfer_done_i) |=> (state_q == ST_DATA || !run_i))
        else $error("transfer abandoned before done");

    // R9: start strobe lasts one cycle.
    assert_start_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start_o |=> !xfer_start_o)
        else $error("start strobe longer than one cycle");

    // R6: dropping hold leaves the hold state next cycle.
    assert_hold_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && primary_i && state_q == ST_HOLD && !hold_i)
        |=> (!run_i || state_q == ST_IDLE || state_q == ST_ADDR))
        else $error("hold not left after request dropped");

    // R7: secondary request persists while waiting for the grant.
    assert_req_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !primary_i && arb_out_o && state_q == ST_HOLD) |=> (arb_out_o || !run_i))
        else $error("request withdrawn before grant");
endmodule

// File: rtl/bus_hold_arbiter.sv
// Top of the two-master bus hold arbiter: synchronizes the asynchronous
// inputs, qualifies the system reset, and runs the ownership state machine.
// Assumes: one clock domain; arb_in_i and sys_rst_i may be asynchronous.
module bus_hold_arbiter
    import hold_arb_pkg::*;
#(
    parameter int SYNC_STAGES    = DEF_SYNC_STAGES,
    parameter int MIN_RST_CYCLES = DEF_MIN_RST
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sys_rst_i,
    input  logic       init_sel_i,
    input  logic       arb_in_i,
    input  logic       xfer_req_i,
    input  logic       xfer_done_i,
    output logic       arb_out_o,
    output logic       drv_oe_o,
    output logic       xfer_start_o,
    output logic [2:0] bus_state_o,
    output logic       role_primary_o,
    output logic       rst_short_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic    rst_req_s;
    logic    hold_s;
    logic    run;
    logic    primary;
    bus_st_e state;

    hold_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sys_rst_i, arb_in_i}),
        .q_o   ({rst_req_s, hold_s})
    );

    rst_qualify #(
        .MIN_CYCLES (MIN_RST_CYCLES)
    ) u_rstq (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_req_i  (rst_req_s),
        .init_pin_i (init_sel_i),
        .run_o      (run),
        .primary_o  (primary),
        .short_o    (rst_short_o)
    );

    hold_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (run),
        .primary_i    (primary),
        .hold_i       (hold_s),
        .xfer_req_i   (xfer_req_i),
        .xfer_done_i  (xfer_done_i),
        .state_o      (state),
        .arb_out_o    (arb_out_o),
        .drv_oe_o     (drv_oe_o),
        .xfer_start_o (xfer_start_o)
    );

    assign bus_state_o    = 3'(state);
    assign role_primary_o = primary;

    // R1: a block held in reset stays off the bus and quiet, one cycle after hold-in.
    assert_quiet_in_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !$past(run)) |-> (!drv_oe_o && !arb_out_o && !xfer_start_o))
        else $error("outputs active while held in reset");
endmodule

// File: tb/bus_hold_arbiter_bench.sv
module bus_hold_arbiter_bench;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sys_rst = 1'b0;
    logic       init_sel = 1'b0;
    logic       arb_in = 1'b0;
    logic       xfer_req = 1'b0;
    logic       xfer_done = 1'b0;
    logic       arb_out;
    logic       drv_oe;
    logic       xfer_start;
    logic [2:0] bus_state;
    logic       role_primary;
    logic       rst_short;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    bus_hold_arbiter u_bus_hold_arbiter (
        .clk            (clk),
        .rst_n          (rst_n),
        .sys_rst_i      (sys_rst),
        .init_sel_i     (init_sel),
        .arb_in_i       (arb_in),
        .xfer_req_i     (xfer_req),
        .xfer_done_i    (xfer_done),
        .arb_out_o      (arb_out),
        .drv_oe_o       (drv_oe),
        .xfer_start_o   (xfer_start),
        .bus_state_o    (bus_state),
        .role_primary_o (role_primary),
        .rst_short_o    (rst_short)
    );

    function automatic int exp_oe(input int st);
        return (st == 1 || st == 2 || st == 3) ? 1 : 0;
    endfunction

    function automatic int exp_start(input int st);
        return (st == 2) ? 1 : 0;
    endfunction

    function automatic int exp_ack_primary(input int st);
        return (st == 5) ? 1 : 0;
    endfunction

    function automatic int legal_primary(input int a, input int b);
        case (a)
            1: return (b == 1 || b == 2 || b == 4) ? 1 : 0;
            2: return (b == 3) ? 1 : 0;
            3: return (b >= 1 && b <= 4) ? 1 : 0;
            4: return (b == 5) ? 1 : 0;
            5: return (b == 1 || b == 2 || b == 5) ? 1 : 0;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Reset pulse of n cycles; optionally noisy inputs with quiet-output checks.
    task automatic do_reset(input int n, input bit init, input bit noisy);
        init_sel = init;
        sys_rst  = 1'b1;
        for (int i = 0; i < n; i++) begin
            tick(1);
            if (noisy) begin
                arb_in    = 1'($urandom);
                xfer_req  = 1'($urandom);
                xfer_done = 1'($urandom);
                if (i >= 5) begin
                    chk("R1 oe in reset", int'(drv_oe), 0);
                    chk("R1 arb_out in reset", int'(arb_out), 0);
                    chk("R1 start in reset", int'(xfer_start), 0);
                end
            end
        end
        sys_rst   = 1'b0;
        arb_in    = 1'b0;
        xfer_req  = 1'b0;
        xfer_done = 1'b0;
        tick(6);
    endtask

    // Raise xfer_req and wait for the start strobe; returns the state seen.
    task automatic start_xfer(output int st_at_start);
        xfer_req    = 1'b1;
        st_at_start = -1;
        for (int i = 0; i < 12; i++) begin
            tick(1);
            if (xfer_start) begin
                st_at_start = int'(bus_state);
                xfer_req    = 1'b0;
                break;
            end
        end
        xfer_req = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int st;
        int prev;
        void'($urandom(32'd4242));
        tick(3);
        rst_n = 1'b1;
        tick(2);

        // R1: held after power-on until a qualified reset.
        chk("R1 state after power-on", int'(bus_state), 0);
        chk("R1 oe after power-on", int'(drv_oe), 0);
        chk("R1 arb_out after power-on", int'(arb_out), 0);

        // R2: one cycle short of the minimum is rejected.
        do_reset(40, 1'b1, 1'b0);
        chk("R2 short flag at 40", int'(rst_short), 1);
        chk("R2 held after short reset", int'(bus_state), 0);
        chk("R1 oe after short reset", int'(drv_oe), 0);

        // R2/R3: exactly the minimum is accepted; primary role.
        do_reset(41, 1'b1, 1'b0);
        chk("R2 short flag at 41", int'(rst_short), 0);
        chk("R3 role primary", int'(role_primary), 1);
        chk("R3 primary starts idle", int'(bus_state), 1);
        chk("R3 primary drives bus", int'(drv_oe), 1);

        // R3: strap changes after reset are ignored.
        init_sel = 1'b0;
        tick(5);
        chk("R3 role kept", int'(role_primary), 1);
        chk("R3 state kept idle", int'(bus_state), 1);

        // R9: transfer start from idle.
        start_xfer(st);
        chk("R9 start in address state", st, 2);
        tick(1);
        chk("R9 data follows address", int'(bus_state), 3);
        chk("R9 start single cycle", int'(xfer_start), 0);

        // R5: hold during data is deferred.
        arb_in = 1'b1;
        tick(6);
        chk("R5 still in data", int'(bus_state), 3);
        chk("R5 no ack during data", int'(arb_out), 0);
        chk("R5 still driving", int'(drv_oe), 1);

        // R8/R4: release cycle, then ack.
        xfer_done = 1'b1;
        tick(1);
        xfer_done = 1'b0;
        chk("R8 release state", int'(bus_state), 4);
        chk("R8 oe off in release", int'(drv_oe), 0);
        chk("R8 no ack yet", int'(arb_out), 0);
        tick(1);
        chk("R4 hold state", int'(bus_state), 5);
        chk("R4 ack asserted", int'(arb_out), 1);
        chk("R8 oe off with ack", int'(drv_oe), 0);

        // R6: hold drops with a pending transfer -> address after sync delay.
        xfer_req = 1'b1;
        arb_in   = 1'b0;
        tick(2);
        chk("R6 ack held through sync", int'(arb_out), 1);
        tick(1);
        chk("R6 address after hold", int'(bus_state), 2);
        chk("R6 ack dropped", int'(arb_out), 0);
        xfer_req = 1'b0;
        tick(1);
        xfer_done = 1'b1;
        tick(1);
        xfer_done = 1'b0;
        chk("R6 idle after last transfer", int'(bus_state), 1);

        // R4: hold and request reach the state machine together; hold wins.
        arb_in = 1'b1;
        tick(2);
        xfer_req = 1'b1;
        tick(1);
        chk("R4 hold wins over request", int'(bus_state), 4);
        chk("R4 no start on hold win", int'(xfer_start), 0);
        tick(1);
        chk("R4 hold reached", int'(bus_state), 5);
        xfer_req = 1'b0;
        arb_in   = 1'b0;
        tick(4);
        chk("R6 idle without request", int'(bus_state), 1);

        // R10/R8/R9: constrained random primary traffic.
        prev = int'(bus_state);
        for (int c = 0; c < 1500; c++) begin
            if ($urandom_range(19) == 0) arb_in = ~arb_in;
            xfer_req  = ($urandom_range(3) == 0);
            xfer_done = ($urandom_range(2) == 0);
            tick(1);
            st = int'(bus_state);
            chk("R10 legal primary move", legal_primary(prev, st), 1);
            chk("R8 oe matches state", int'(drv_oe), exp_oe(st));
            chk("R9 start matches state", int'(xfer_start), exp_start(st));
            chk("R4 ack matches state", int'(arb_out), exp_ack_primary(st));
            prev = st;
        end

        // R1/R3: noisy reset into the secondary role.
        do_reset(50, 1'b0, 1'b1);
        chk("R3 role secondary", int'(role_primary), 0);
        chk("R3 secondary starts in hold", int'(bus_state), 5);
        chk("R3 secondary not driving", int'(drv_oe), 0);
        chk("R7 no request when idle", int'(arb_out), 0);

        // R7: request held while waiting for the grant.
        xfer_req = 1'b1;
        tick(1);
        chk("R7 request raised", int'(arb_out), 1);
        tick(10);
        chk("R7 request still held", int'(arb_out), 1);
        chk("R7 waiting in hold", int'(bus_state), 5);
        chk("R7 no drive before grant", int'(drv_oe), 0);
        arb_in = 1'b1;
        st = -1;
        for (int i = 0; i < 8; i++) begin
            tick(1);
            if (xfer_start) begin
                st = int'(bus_state);
                xfer_req = 1'b0;
                break;
            end
        end
        chk("R7 address after grant", st, 2);
        tick(1);
        chk("R7 data while owning", int'(bus_state), 3);
        chk("R7 request kept while owning", int'(arb_out), 1);
        chk("R7 driving while owning", int'(drv_oe), 1);
        xfer_done = 1'b1;
        tick(1);
        xfer_done = 1'b0;
        chk("R7 release after last transfer", int'(bus_state), 4);
        chk("R7 drive off at release", int'(drv_oe), 0);
        tick(1);
        chk("R7 back in hold", int'(bus_state), 5);
        chk("R7 request dropped", int'(arb_out), 0);
        arb_in = 1'b0;
        tick(3);

        // R7/R9: random secondary traffic with a responsive other master.
        for (int c = 0; c < 1500; c++) begin
            if (arb_in != arb_out && $urandom_range(2) == 0) arb_in = arb_out;
            if (!xfer_req) xfer_req = ($urandom_range(5) == 0);
            xfer_done = ($urandom_range(2) == 0);
            tick(1);
            if (xfer_start) xfer_req = 1'b0;
            st = int'(bus_state);
            chk("R9 oe matches state (secondary)", int'(drv_oe), exp_oe(st));
            chk("R9 start matches state (secondary)", int'(xfer_start), exp_start(st));
            if (drv_oe) chk("R7 request held while driving", int'(arb_out), 1);
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule